// File: doc/BRIEF.md
# MDIO Management Interface Controller

This block is a station management master for an external Ethernet PHY. It runs clause-22 read and write frames on a management clock (MDC) that it derives from the system clock, and on a bidirectional data line (MDIO). The data line is split into an output value, an output enable and an input. Software works through two 16-bit registers, a command register and a data register. Both are written through a simple strobe port and read back through dedicated output buses.

To write to the PHY, software first loads the data register with the 16-bit value. It then writes the command register with the busy bit set. To read, software writes only the command register with busy set. In both cases software polls `busy` until it drops. After a read, the value sampled from the PHY sits in the data register. A 3-bit clock-range code in the command register selects the MDC divisor. Pick the code that keeps MDC between 1 and 2.5 MHz for the system clock in use. System clocks below 25 MHz are not supported.

The register write port is a control port, not a stream. It has no ready signal and no back-pressure. A write that arrives while `busy` is high is dropped in full. Software must wait for `busy` to clear before it writes either register.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy`, `mdc` and `mdio_oe` are 0, and `rd_cmd` and `data_q` read 0.
- R2: Command register layout: bits 15:11 PHY address, bits 10:6 register index, bit 5 reads 0, bits 4:2 clock-range code, bit 1 direction (1 = write, 0 = read), bit 0 busy. A command write (`wr_sel`=0) with bit 0 set sets `busy` on the next clock edge. A command write with bit 0 clear only stores the fields and starts no activity on MDC.
- R3: Every frame is 64 MDC bits, most significant bit first. The order is 32 ones, start code 01, opcode (10 for read, 01 for write), the 5-bit PHY address, then the 5-bit register index.
- R4: In a write frame, the turnaround is 10, followed by the 16 data-register bits. `mdio_oe` stays high for the whole frame.
- R5: In a read frame, `mdio_oe` is low for both turnaround bits and all 16 data bits. The controller samples `mdio_i` on the MDC rising edge of each data bit. When `busy` clears, `data_q` holds the sampled value, with the first bit as the MSB.
- R6: The MDC period in system clocks is 16, 26, 42, 62 or 102 for clock-range codes 0, 1, 2, 3 and 4 respectively. Codes 5, 6 and 7 divide by 102.
- R7: A new output bit is presented on MDIO only at a falling edge of MDC, or at launch while MDC is low.
- R8: While `busy` is high, writes to either register are ignored. They change neither register, and a command write cannot start a new frame.
- R9: While `busy` is low, MDC is held low and MDIO is released (`mdio_oe` = 0).
- R10: `busy` clears at the falling edge of MDC that ends the 64th bit, after exactly 64 MDC rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 command, 1 data |
| wr_data | input | 16 | Register write value |
| rd_cmd | output | 16 | Command register readback, with the live busy flag in bit 0 |
| data_q | output | 16 | Data register readback |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The assertions assume reset is applied before the first edge that matters. They also assume the only way the registers change is the write strobe, so the lock-out while busy is visible at the readback buses. They place no constraint on `mdio_i`, and hold whatever the PHY drives. The bench keeps its register writes on falling clock edges, each one cycle long. It drives `mdio_i` from a small PHY model that presents each read bit right after the MDC rising edge before the one that samples it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int DATA_W    = 16;
  localparam int RANGE_W   = 3;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
  localparam int MAX_DIV   = 102;
  localparam int CNT_W     = $clog2(MAX_DIV);

  typedef struct packed {
    logic [PHY_W-1:0]   phy;
    logic [REG_W-1:0]   regad;
    logic [RANGE_W-1:0] range;
    logic               wr;
  } cmd_t;

  function automatic logic [CNT_W-1:0] half_period(input logic [RANGE_W-1:0] code);
    int unsigned d;
    case (code)
      3'd0:    d = 16;
      3'd1:    d = 26;
      3'd2:    d = 42;
      3'd3:    d = 62;
      default: d = MAX_DIV;
    endcase
    return CNT_W'(d / 2);
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick      = run && (cnt == half - CNT_W'(1));
  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter #(
  parameter int FRAME_LEN = 64,
  parameter int DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FRAME_LEN-1:0] frame,
  input  logic                 is_read,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic                 mdio_i,
  output logic                 active,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic [DATA_W-1:0]    rx_data
);
  localparam int BIT_W = $clog2(FRAME_LEN);
  localparam logic [BIT_W-1:0] TA_IDX   = BIT_W'(FRAME_LEN - DATA_W - 2);
  localparam logic [BIT_W-1:0] DATA_IDX = BIT_W'(FRAME_LEN - DATA_W);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] shreg;
  logic [BIT_W-1:0]     bitcnt;
  logic                 rd;

  assign done    = active && fall_tick && (bitcnt == LAST_IDX);
  assign mdio_oe = active && !(rd && (bitcnt >= TA_IDX));
  assign mdio_o  = active ? shreg[FRAME_LEN-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bitcnt  <= '0;
      rd      <= 1'b0;
      active  <= 1'b0;
      rx_data <= '0;
    end else if (start) begin
      shreg   <= frame;
      bitcnt  <= '0;
      rd      <= is_read;
      active  <= 1'b1;
      rx_data <= '0;
    end else if (active) begin
      if (rise_tick && rd && (bitcnt >= DATA_IDX))
        rx_data <= {rx_data[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (bitcnt == LAST_IDX) begin
          active <= 1'b0;
        end else begin
          shreg  <= {shreg[FRAME_LEN-2:0], 1'b0};
          bitcnt <= bitcnt + BIT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_cmd,
  output logic [15:0] data_q,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  cmd_t                 cmd_q;
  cmd_t                 cmd_in;
  logic                 accept;
  logic                 start;
  logic [FRAME_LEN-1:0] frame;
  logic [CNT_W-1:0]     half;
  logic                 rise_tick, fall_tick;
  logic                 active, done;
  logic [DATA_W-1:0]    rx_data;

  assign cmd_in = '{phy:   wr_data[15:11],
                    regad: wr_data[10:6],
                    range: wr_data[4:2],
                    wr:    wr_data[1]};
  assign accept = wr_en && !busy;
  assign start  = accept && !wr_sel && wr_data[0];

  assign frame = {{PRE_LEN{1'b1}}, 2'b01,
                  cmd_in.wr ? 2'b01 : 2'b10,
                  cmd_in.phy, cmd_in.regad,
                  cmd_in.wr ? 2'b10 : 2'b00,
                  cmd_in.wr ? data_q : {DATA_W{1'b0}}};

  assign half   = half_period(cmd_q.range);
  assign rd_cmd = {cmd_q.phy, cmd_q.regad, 1'b0, cmd_q.range, cmd_q.wr, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      busy   <= 1'b0;
    end else begin
      if (accept && !wr_sel) cmd_q  <= cmd_in;
      if (accept && wr_sel)  data_q <= wr_data;
      if (start) busy <= 1'b1;
      if (done) begin
        busy <= 1'b0;
        if (!cmd_q.wr) data_q <= rx_data;
      end
    end
  end

  mdio_clkgen #(.CNT_W(CNT_W)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (active),
    .half      (half),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_shifter #(.FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .frame     (frame),
    .is_read   (!cmd_in.wr),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .active    (active),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .rx_data   (rx_data)
  );
endmodule

// File: rtl/mdio_master_checker.sv
module mdio_master_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rd_cmd,
  input logic [15:0] data_q
);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_mdc_needs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy);

  p_clear_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mdc));

  p_cmd_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rd_cmd[15:1]));

  p_data_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_cmd[1]) |=> $stable(data_q));

  p_write_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_cmd[1]) |-> mdio_oe);

  p_launch_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> !mdc);
endmodule

bind mdio_master mdio_master_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .rd_cmd  (rd_cmd),
  .data_q  (data_q)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_cmd, data_q;
  logic        busy, mdc, mdio_o, mdio_oe, mdio_i;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_cmd(rd_cmd), .data_q(data_q), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  logic        cap_o  [64];
  logic        cap_oe [64];
  int          ncap = 0;
  int          last_rise = 0;
  int          exp_div = 16;
  int          per_bad = 0;
  logic [15:0] phy_val = '0;

  always @(posedge mdc) begin
    if (ncap < 64) begin
      cap_o[ncap]  = mdio_o;
      cap_oe[ncap] = mdio_oe;
    end
    if (ncap > 0 && (cyc - last_rise) != exp_div) per_bad++;
    last_rise = cyc;
    ncap++;
  end

  // PHY model: bit k of the read data is presented after rising edge 48+k
  function automatic logic phy_bit(int n);
    if (n >= 48 && n < 64) return phy_val[4'(63 - n)];
    return 1'b1;
  endfunction
  assign mdio_i = phy_bit(ncap);

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int div_of(int code);
    case (code)
      0: return 16;
      1: return 26;
      2: return 42;
      3: return 62;
      default: return 102;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(logic [4:0] phy, logic [4:0] ra, logic wr,
                                            logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra,
            (wr ? 2'b10 : 2'b00), (wr ? wd : 16'h0)};
  endfunction

  task automatic reg_write(logic sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic launch(logic [4:0] phy, logic [4:0] ra, logic wr, int code,
                        logic [15:0] wd, logic [15:0] rv);
    exp_div = div_of(code);
    ncap = 0; per_bad = 0; phy_val = rv;
    if (wr) reg_write(1'b1, wd);
    reg_write(1'b0, {phy, ra, 1'b0, 3'(code), wr, 1'b1});
    check_eq("R2", "busy after launch", int'(busy), 1);
  endtask

  task automatic finish(logic [4:0] phy, logic [4:0] ra, logic wr, logic [15:0] wd);
    int   wait_c = 0;
    int   hdr_bad = 0, tail_bad = 0, oe_bad = 0;
    logic [63:0] ef;
    while (busy && wait_c < 20000) begin
      @(negedge clk);
      wait_c++;
    end
    check_eq("R10", "busy cleared before timeout", int'(busy), 0);
    check_eq("R10", "MDC rising edges", ncap, 64);
    check_eq("R6", "MDC period mismatches", per_bad, 0);
    check_eq("R9", "idle mdc/oe", int'({mdc, mdio_oe}), 0);
    ef = exp_frame(phy, ra, wr, wd);
    for (int i = 0; i < 64; i++) begin
      if (i < 46) begin
        if (cap_o[i] !== ef[63-i]) hdr_bad++;
        if (cap_oe[i] !== 1'b1) oe_bad++;
      end else if (wr) begin
        if (cap_o[i] !== ef[63-i]) tail_bad++;
        if (cap_oe[i] !== 1'b1) oe_bad++;
      end else begin
        if (cap_oe[i] !== 1'b0) oe_bad++;
      end
    end
    check_eq("R3", "header bit mismatches", hdr_bad, 0);
    if (wr) begin
      check_eq("R4", "turnaround/data mismatches", tail_bad, 0);
      check_eq("R4", "output enable gaps", oe_bad, 0);
    end else begin
      check_eq("R5", "output enable pattern errors", oe_bad, 0);
    end
  endtask

  task automatic t_reset();
    check_eq("R1", "busy", int'(busy), 0);
    check_eq("R1", "mdc", int'(mdc), 0);
    check_eq("R1", "mdio_oe", int'(mdio_oe), 0);
    check_eq("R1", "rd_cmd", int'(rd_cmd), 0);
    check_eq("R1", "data_q", int'(data_q), 0);
  endtask

  task automatic t_config_only();
    ncap = 0;
    reg_write(1'b0, {5'd9, 5'd17, 1'b0, 3'd2, 1'b1, 1'b0});
    repeat (60) @(negedge clk);
    check_eq("R2", "no busy without flag", int'(busy), 0);
    check_eq("R2", "no MDC activity", ncap, 0);
    check_eq("R2", "fields stored", int'(rd_cmd), int'({5'd9, 5'd17, 1'b0, 3'd2, 1'b1, 1'b0}));
  endtask

  task automatic t_write(int code, logic [4:0] phy, logic [4:0] ra, logic [15:0] wd);
    launch(phy, ra, 1'b1, code, wd, 16'h0);
    finish(phy, ra, 1'b1, wd);
    check_eq("R4", "data register kept after write", int'(data_q), int'(wd));
  endtask

  task automatic t_read(int code, logic [4:0] phy, logic [4:0] ra, logic [15:0] rv);
    launch(phy, ra, 1'b0, code, 16'h0, rv);
    finish(phy, ra, 1'b0, 16'h0);
    check_eq("R5", "read result", int'(data_q), int'(rv));
  endtask

  task automatic t_ignore_busy();
    logic [15:0] cmd_before;
    launch(5'd3, 5'd4, 1'b1, 0, 16'hBEEF, 16'h0);
    cmd_before = rd_cmd;
    repeat (100) @(negedge clk);
    reg_write(1'b1, 16'h1357);
    reg_write(1'b0, {5'd30, 5'd29, 1'b0, 3'd4, 1'b0, 1'b1});
    check_eq("R8", "data reg during busy", int'(data_q), 16'hBEEF);
    check_eq("R8", "cmd fields during busy", int'(rd_cmd[15:1]), int'(cmd_before[15:1]));
    finish(5'd3, 5'd4, 1'b1, 16'hBEEF);
    repeat (30) @(negedge clk);
    check_eq("R8", "no relaunch", int'(busy), 0);
    check_eq("R8", "data reg after frame", int'(data_q), 16'hBEEF);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_config_only();
    for (int c = 0; c < 8; c++)
      t_write(c, 5'(c + 1), 5'(31 - c), 16'hA000 + 16'(c * 16'h0111));
    t_read(0, 5'h15, 5'h0A, 16'hA5C3);
    t_read(2, 5'h01, 5'h1F, 16'h1234);
    t_read(4, 5'h1E, 5'h02, 16'hFFFE);
    t_ignore_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule